// File: doc/BRIEF.md
# Branch Stall Hazard Detector

This block is the control-hazard unit of a five-stage in-order pipeline that resolves conditional branches by stalling. It holds the fetch address register and the four inter-stage registers. Those registers are IF/ID, ID/EX, EX/MEM and MEM/WB, and each carries a valid bit, a branch marker, a compare-mode bit, a displacement and the instruction's address. The instruction memory and the register file sit outside the block. The fetch stage supplies the decoded branch fields for the word at the current fetch address. A register-read stub supplies the two operands of whatever instruction occupies ID/EX.

A branch can sit in IF/ID, ID/EX or EX/MEM. While it does, the unit freezes the fetch address and writes a bubble into IF/ID, and the stages after IF/ID keep moving so that the bubbles flow on. The outcome is found in EX and registered beside the branch in EX/MEM. The target is formed while the branch is in MEM. At the end of that cycle a taken branch redirects the fetch address.

A not-taken branch behaves in one of two ways, chosen by a mode input. In plain mode the fall-through address is held until the branch reaches WB. In early-resume mode the fall-through instruction is accepted during the MEM cycle, which saves one cycle.

Top module: `bsh_top`

## Requirements
- R1: While reset is asserted, the fetch address `pc_q` reads 0 and all four bits of `stg_vld` read 0. Stage index 0 is IF/ID, 1 is ID/EX, 2 is EX/MEM and 3 is MEM/WB.
- R2: While a valid branch is in IF/ID or ID/EX, `pc_we` is 0, `ifid_bubble` is 1 and `pc_q` keeps its value.
- R3: On every clock, stages 1 to 3 take the previous contents of the stage before them, bubbles included. The address of stage k is `stg_pc[k*32 +: 32]`.
- R4: A branch with `if_cmp2`=1 is taken when the two operands are equal. A branch with `if_cmp2`=0 is taken when `ex_opa` is zero. The outcome is registered as the branch moves from ID/EX to EX/MEM.
- R5: The branch target is the branch address plus 4, plus the sign-extended displacement shifted left by two.
- R6: When a taken branch is in EX/MEM, `pc_we` and `pc_sel` are 1, IF/ID receives a bubble, and the next `pc_q` is the target.
- R7: When `opt_nt`=0 and a not-taken branch is in EX/MEM, `pc_we` is 0 and IF/ID receives a bubble. The fall-through instruction enters IF/ID four cycles after the branch did.
- R8: When `opt_nt`=1 and a not-taken branch is in EX/MEM, `pc_we` is 1 and `pc_sel` is 0. The fall-through instruction enters IF/ID in that same cycle and `pc_q` advances by 4, so the gap is three cycles.
- R9: With no valid branch in stages 0 to 2, `pc_q` advances by 4, `ifid_bubble` is 0, and the fetched instruction enters IF/ID on the next clock.
- R10: A taken branch's target instruction enters IF/ID four cycles after the branch did, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_nt | input | 1 | 1 selects early resume on not-taken branches |
| if_br | input | 1 | Word at `pc_q` is a conditional branch |
| if_cmp2 | input | 1 | Branch compares two operands (1) or operand A with zero (0) |
| if_disp | input | 16 | Branch displacement in words, signed |
| ex_opa | input | 32 | First register operand of the ID/EX instruction |
| ex_opb | input | 32 | Second register operand of the ID/EX instruction |
| pc_q | output | 32 | Fetch address |
| pc_we | output | 1 | Fetch address write enable |
| pc_sel | output | 1 | Fetch address source: 1 target, 0 sequential |
| ifid_bubble | output | 1 | IF/ID is loaded with a bubble this cycle |
| stg_vld | output | 4 | Per-stage valid bits, index 0 = IF/ID |
| stg_br | output | 4 | Per-stage branch markers |
| stg_pc | output | 128 | Per-stage instruction addresses, 32 bits each |

## Verification
The program loop mixes straight-line code with five branches. One is a taken compare-with-zero forward branch. Two are back-to-back not-taken two-operand branches, which show that a second branch arriving right after a resumed one is stalled in turn. Next comes a not-taken compare-with-zero branch, then a taken two-operand backward branch with a negative displacement, which checks the sign extension of the target. The whole loop runs once in each mode. Comparing the gaps between IF/ID entries separates the 3-cycle cost of a taken branch from the 3- or 2-cycle cost of a not-taken one, and both from the single cycle of sequential code.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  parameter int unsigned ADDR_W = 32;
  parameter int unsigned DISP_W = 16;
  parameter int unsigned N_STG  = 4;

  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned WORD_SHIFT = 2;
  localparam int unsigned STG_IFID   = 0;
  localparam int unsigned STG_IDEX   = 1;
  localparam int unsigned STG_EXMEM  = 2;

  typedef struct packed {
    logic              vld;
    logic              br;
    logic              cmp2;
    logic [DISP_W-1:0] disp;
    logic [ADDR_W-1:0] pc;
  } stg_t;

  function automatic logic [ADDR_W-1:0] br_target(input logic [ADDR_W-1:0] pc,
                                                   input logic [DISP_W-1:0] disp);
    logic [ADDR_W-1:0] off;
    off = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp} << WORD_SHIFT;
    return pc + ADDR_W'(INSN_BYTES) + off;
  endfunction

endpackage

// File: rtl/bsh_resolve.sv
module bsh_resolve #(
  parameter int unsigned OPW = 32
) (
  input  logic           cmp2,
  input  logic [OPW-1:0] opa,
  input  logic [OPW-1:0] opb,
  output logic           taken
);

  logic eq_pair;
  logic eq_zero;

  always_comb begin
    eq_pair = (opa == opb);
    eq_zero = (opa == '0);
    taken   = cmp2 ? eq_pair : eq_zero;
  end

endmodule

// File: rtl/bsh_hazard_unit.sv
module bsh_hazard_unit #(
  parameter bit HAS_OPT = 1'b1
) (
  input  logic opt_nt,
  input  logic id_br,
  input  logic ex_br,
  input  logic mem_br,
  input  logic mem_taken,
  output logic pc_we,
  output logic pc_sel,
  output logic ifid_bubble
);

  logic early_ok;

  generate
    if (HAS_OPT) begin : g_opt
      assign early_ok = opt_nt;
    end else begin : g_noopt
      logic unused_opt;
      assign unused_opt = opt_nt;
      assign early_ok   = 1'b0;
    end
  endgenerate

  always_comb begin
    pc_we       = 1'b1;
    pc_sel      = 1'b0;
    ifid_bubble = 1'b0;
    if (mem_br) begin
      if (mem_taken) begin
        pc_we       = 1'b1;
        pc_sel      = 1'b1;
        ifid_bubble = 1'b1;
      end else if (early_ok) begin
        pc_we       = 1'b1;
        pc_sel      = 1'b0;
        ifid_bubble = 1'b0;
      end else begin
        pc_we       = 1'b0;
        ifid_bubble = 1'b1;
      end
    end else if (id_br || ex_br) begin
      pc_we       = 1'b0;
      ifid_bubble = 1'b1;
    end
  end

endmodule

// File: rtl/bsh_pc_reg.sv
module bsh_pc_reg
  import bsh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_we,
  input  logic              pc_sel,
  input  logic [ADDR_W-1:0] tgt,
  output logic [ADDR_W-1:0] pc_q
);

  logic [ADDR_W-1:0] pc_d;

  always_comb begin
    pc_d = pc_q;
    if (pc_we) begin
      pc_d = pc_sel ? tgt : (pc_q + ADDR_W'(INSN_BYTES));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

endmodule

// File: rtl/bsh_pipe.sv
module bsh_pipe
  import bsh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  stg_t id_d,
  input  logic ex_taken,
  output stg_t stg_q [N_STG],
  output logic mem_taken
);

  stg_t stg_d [N_STG];
  logic tk_d;
  logic adv_en;

  assign adv_en = 1'b1;

  always_comb begin
    stg_d[0] = id_d;
    tk_d     = ex_taken && stg_q[STG_IDEX].vld && stg_q[STG_IDEX].br;
  end

  generate
    for (genvar k = 1; k < N_STG; k++) begin : g_shift
      always_comb begin
        stg_d[k] = stg_q[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_STG; k++) begin
        stg_q[k] <= '0;
      end
      mem_taken <= 1'b0;
    end else if (adv_en) begin
      for (int k = 0; k < N_STG; k++) begin
        stg_q[k] <= stg_d[k];
      end
      mem_taken <= tk_d;
    end
  end

endmodule

// File: rtl/bsh_top.sv
module bsh_top
  import bsh_pkg::*;
#(
  parameter int unsigned OPW     = 32,
  parameter bit          HAS_OPT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    opt_nt,
  input  logic                    if_br,
  input  logic                    if_cmp2,
  input  logic [DISP_W-1:0]       if_disp,
  input  logic [OPW-1:0]          ex_opa,
  input  logic [OPW-1:0]          ex_opb,
  output logic [ADDR_W-1:0]       pc_q,
  output logic                    pc_we,
  output logic                    pc_sel,
  output logic                    ifid_bubble,
  output logic [N_STG-1:0]        stg_vld,
  output logic [N_STG-1:0]        stg_br,
  output logic [N_STG*ADDR_W-1:0] stg_pc
);

  stg_t              stg [N_STG];
  stg_t              id_d;
  logic              ex_tk;
  logic              mem_tk;
  logic              ex_cmp2;
  logic              id_br;
  logic              ex_br;
  logic              mem_br;
  logic [ADDR_W-1:0] mem_tgt;

  always_comb begin
    id_d = '0;
    if (!ifid_bubble) begin
      id_d.vld  = 1'b1;
      id_d.br   = if_br;
      id_d.cmp2 = if_cmp2;
      id_d.disp = if_disp;
      id_d.pc   = pc_q;
    end
  end

  always_comb begin
    id_br   = stg[STG_IFID].vld  && stg[STG_IFID].br;
    ex_br   = stg[STG_IDEX].vld  && stg[STG_IDEX].br;
    mem_br  = stg[STG_EXMEM].vld && stg[STG_EXMEM].br;
    ex_cmp2 = stg[STG_IDEX].cmp2;
    mem_tgt = br_target(stg[STG_EXMEM].pc, stg[STG_EXMEM].disp);
  end

  bsh_resolve #(.OPW(OPW)) u_resolve (
    .cmp2  (ex_cmp2),
    .opa   (ex_opa),
    .opb   (ex_opb),
    .taken (ex_tk)
  );

  bsh_hazard_unit #(.HAS_OPT(HAS_OPT)) u_hazard (
    .opt_nt      (opt_nt),
    .id_br       (id_br),
    .ex_br       (ex_br),
    .mem_br      (mem_br),
    .mem_taken   (mem_tk),
    .pc_we       (pc_we),
    .pc_sel      (pc_sel),
    .ifid_bubble (ifid_bubble)
  );

  bsh_pc_reg u_pc (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc_we  (pc_we),
    .pc_sel (pc_sel),
    .tgt    (mem_tgt),
    .pc_q   (pc_q)
  );

  bsh_pipe u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_d      (id_d),
    .ex_taken  (ex_tk),
    .stg_q     (stg),
    .mem_taken (mem_tk)
  );

  always_comb begin
    for (int k = 0; k < N_STG; k++) begin
      stg_vld[k]                 = stg[k].vld;
      stg_br[k]                  = stg[k].br;
      stg_pc[k*ADDR_W +: ADDR_W] = stg[k].pc;
    end
  end

endmodule

// File: rtl/bsh_checker.sv
module bsh_checker
  import bsh_pkg::*;
#(
  parameter int unsigned OPW = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    opt_nt,
  input logic [ADDR_W-1:0]       pc_q,
  input logic [N_STG-1:0]        stg_vld,
  input logic [N_STG-1:0]        stg_br,
  input logic [N_STG*ADDR_W-1:0] stg_pc,
  input logic                    mem_taken,
  input logic [ADDR_W-1:0]       mem_tgt,
  input logic                    ex_cmp2,
  input logic [OPW-1:0]          ex_opa,
  input logic [OPW-1:0]          ex_opb
);

  logic c_id_br, c_ex_br, c_mem_br;
  assign c_id_br  = stg_vld[0] && stg_br[0];
  assign c_ex_br  = stg_vld[1] && stg_br[1];
  assign c_mem_br = stg_vld[2] && stg_br[2];

  a_r1_reset_pc: assert property (@(posedge clk) !rst_n |-> (pc_q == '0 && stg_vld == '0));

  a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (c_id_br || c_ex_br) |=> (pc_q == $past(pc_q)) && !stg_vld[0]);

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    stg_vld[1] |=> stg_vld[2] && (stg_pc[2*ADDR_W +: ADDR_W] == $past(stg_pc[ADDR_W +: ADDR_W])));

  a_r4_resolve: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ex_br && ex_cmp2) |=> (mem_taken == ($past(ex_opa) == $past(ex_opb))));

  a_r6_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mem_br && mem_taken) |=> (pc_q == $past(mem_tgt)) && !stg_vld[0]);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mem_br && !mem_taken && !opt_nt) |=> (pc_q == $past(pc_q)) && !stg_vld[0]);

  a_r8_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mem_br && !mem_taken && opt_nt) |=>
      (pc_q == $past(pc_q) + ADDR_W'(INSN_BYTES)) && stg_vld[0] && (stg_pc[ADDR_W-1:0] == $past(pc_q)));

  a_r9_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_id_br && !c_ex_br && !c_mem_br) |=>
      (pc_q == $past(pc_q) + ADDR_W'(INSN_BYTES)) && stg_vld[0]);

endmodule

bind bsh_top bsh_checker #(.OPW(OPW)) u_bsh_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .opt_nt    (opt_nt),
  .pc_q      (pc_q),
  .stg_vld   (stg_vld),
  .stg_br    (stg_br),
  .stg_pc    (stg_pc),
  .mem_taken (mem_tk),
  .mem_tgt   (mem_tgt),
  .ex_cmp2   (ex_cmp2),
  .ex_opa    (ex_opa),
  .ex_opb    (ex_opb)
);

// File: tb/test_bsh_top.sv
`timescale 1ns/1ps
module test_bsh_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         opt_nt;
  logic         if_br;
  logic         if_cmp2;
  logic [15:0]  if_disp;
  logic [31:0]  ex_opa;
  logic [31:0]  ex_opb;
  logic [31:0]  pc_q;
  logic         pc_we;
  logic         pc_sel;
  logic         ifid_bubble;
  logic [3:0]   stg_vld;
  logic [3:0]   stg_br;
  logic [127:0] stg_pc;

  bsh_top i_bsh_top (
    .clk(clk), .rst_n(rst_n), .opt_nt(opt_nt), .if_br(if_br), .if_cmp2(if_cmp2),
    .if_disp(if_disp), .ex_opa(ex_opa), .ex_opb(ex_opb), .pc_q(pc_q), .pc_we(pc_we),
    .pc_sel(pc_sel), .ifid_bubble(ifid_bubble), .stg_vld(stg_vld), .stg_br(stg_br),
    .stg_pc(stg_pc)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int m_vld [4];
  int m_pc  [4];
  bit m_tk;
  int m_f;
  int last_pc, last_cyc;
  bit have_last;

  // instruction memory stub
  function automatic bit im_br(int a);
    return (a == 16) || (a == 64) || (a == 68) || (a == 80) || (a == 88);
  endfunction
  function automatic bit im_cmp2(int a);
    return (a == 64) || (a == 68) || (a == 88);
  endfunction
  function automatic int im_disp(int a);
    case (a)
      16: return 8;
      64: return 5;
      68: return 3;
      80: return 2;
      88: return -23;
      default: return 0;
    endcase
  endfunction
  // register read stub
  function automatic int op_a(int a);
    case (a)
      16: return 0;
      64: return 3;
      68: return 7;
      80: return 5;
      88: return 9;
      default: return 1;
    endcase
  endfunction
  function automatic int op_b(int a);
    case (a)
      64: return 4;
      68: return 1;
      88: return 9;
      default: return 2;
    endcase
  endfunction
  function automatic bit tk_of(int a);
    return im_cmp2(a) ? (op_a(a) == op_b(a)) : (op_a(a) == 0);
  endfunction

  function automatic int pcs(int k);
    return int'(stg_pc[k*32 +: 32]);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    bit bi, be, bm;
    int e_we, e_sel, e_bub;
    bi = (m_vld[0] != 0) && im_br(m_pc[0]);
    be = (m_vld[1] != 0) && im_br(m_pc[1]);
    bm = (m_vld[2] != 0) && im_br(m_pc[2]);
    e_we = 1; e_sel = 0; e_bub = 0;
    if (bm) begin
      if (m_tk) begin e_we = 1; e_sel = 1; e_bub = 1; end
      else if (opt_nt) begin e_we = 1; e_sel = 0; e_bub = 0; end
      else begin e_we = 0; e_bub = 1; end
    end else if (bi || be) begin
      e_we = 0; e_bub = 1;
    end
    chk("R5 R6 R7 R8 R9", "pc_q", int'(pc_q), m_f);
    chk("R2 R7", "pc_we", int'(pc_we), e_we);
    chk("R2 R6", "ifid_bubble", int'(ifid_bubble), e_bub);
    if (e_we == 1) chk("R6 R9", "pc_sel", int'(pc_sel), e_sel);
    for (int k = 0; k < 4; k++) begin
      chk("R3", $sformatf("stage%0d valid", k), int'(stg_vld[k]), m_vld[k]);
      if (m_vld[k] != 0) chk("R3", $sformatf("stage%0d pc", k), pcs(k), m_pc[k]);
    end
    // entry-gap checks into IF/ID
    if (stg_vld[0]) begin
      int p;
      p = pcs(0);
      if (have_last) begin
        case (last_pc)
          16: begin chk("R10 R4", "target after taken", p, 52); chk("R10", "taken gap", cyc - last_cyc, 4); end
          88: begin chk("R10 R5", "backward target", p, 0); chk("R10", "taken gap", cyc - last_cyc, 4); end
          64, 68, 80: begin
            chk("R4 R7 R8", "fall-through", p, last_pc + 4);
            if (opt_nt) chk("R8", "early resume gap", cyc - last_cyc, 3);
            else        chk("R7", "plain resume gap", cyc - last_cyc, 4);
          end
          default: begin chk("R9", "sequential next", p, last_pc + 4); chk("R9", "sequential gap", cyc - last_cyc, 1); end
        endcase
      end
      last_pc = p; last_cyc = cyc; have_last = 1'b1;
    end
  endtask

  task automatic drive();
    int a;
    a = int'(pc_q);
    if_br   = im_br(a);
    if_cmp2 = im_cmp2(a);
    if_disp = 16'(im_disp(a));
    ex_opa  = 32'(op_a(pcs(1)));
    ex_opb  = 32'(op_b(pcs(1)));
  endtask

  task automatic step();
    int n_vld [4];
    int n_pc [4];
    bit n_tk, bi, be, bm;
    int n_f;
    bi = (m_vld[0] != 0) && im_br(m_pc[0]);
    be = (m_vld[1] != 0) && im_br(m_pc[1]);
    bm = (m_vld[2] != 0) && im_br(m_pc[2]);
    n_tk = be && tk_of(m_pc[1]);
    for (int k = 1; k < 4; k++) begin n_vld[k] = m_vld[k-1]; n_pc[k] = m_pc[k-1]; end
    n_vld[0] = 0; n_pc[0] = 0; n_f = m_f;
    if (bm && m_tk) n_f = m_pc[2] + 4 + im_disp(m_pc[2]) * 4;
    else if (bm && opt_nt) begin n_vld[0] = 1; n_pc[0] = m_f; n_f = m_f + 4; end
    else if (!bm && !bi && !be) begin n_vld[0] = 1; n_pc[0] = m_f; n_f = m_f + 4; end
    for (int k = 0; k < 4; k++) begin m_vld[k] = n_vld[k]; m_pc[k] = n_pc[k]; end
    m_tk = n_tk; m_f = n_f;
    cyc++;
  endtask

  task automatic do_reset(bit mode);
    rst_n = 1'b0;
    opt_nt = mode;
    if_br = 1'b0; if_cmp2 = 1'b0; if_disp = '0; ex_opa = '0; ex_opb = '0;
    repeat (3) begin
      @(negedge clk);
      chk("R1", "reset pc", int'(pc_q), 0);
      chk("R1", "reset valids", int'(stg_vld), 0);
    end
    for (int k = 0; k < 4; k++) begin m_vld[k] = 0; m_pc[k] = 0; end
    m_tk = 1'b0; m_f = 0; have_last = 1'b0; cyc = 0;
    drive();
    rst_n = 1'b1;
    step();
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      compare();
      drive();
      step();
    end
  endtask

  initial begin
    do_reset(1'b0);
    run(150);
    do_reset(1'b1);
    run(150);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule